// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Gating

This block receives asynchronous serial characters on a shared multidrop line. Each character carries one extra bit after its data bits that marks it as an address character. The block decides, one character at a time, whether the character is written to a downstream receive FIFO. Address characters always go through. Plain data characters go through only while a sticky address flag is set. The first address character on the line therefore opens the gate for the data that follows it. Software closes the gate again with a write-1-to-clear strobe if the traffic is not meant for this node.

The receiver runs from a single clock plus a 16x oversampling enable pulse. Word length, parity mode and stop length are static configuration inputs. A per-frame address status bit shows the address bit of the most recent character. A level interrupt request tells software that the sticky address flag is set while the interrupt is enabled. Separate strobes let software clear the sticky flag, or force both flags high.

Top module: `addr_uart_rx`

## Requirements
- R1: A frame is a low start bit, then `wordLen`+5 data bits sent LSB first (`wordLen` 0..3 gives 5..8 bits), then one address bit, then a parity bit when `parMode` is non-zero, then the stop bits. The character is presented on `fifoData` right-aligned, with the unused upper bits zero.
- R2: A falling edge on `rxIn` starts a frame only if the line is still low at the eighth tick. Otherwise the receiver returns to idle, nothing is written and no flag changes.
- R3: At the end of every frame, `addrStat` takes the value of that frame's address bit.
- R4: A frame whose address bit is 1 is always written: `fifoWr` pulses for one clock cycle and `addrSticky` becomes 1.
- R5: A frame whose address bit is 0 is written only if `addrSticky` was 1 before the frame ended. Otherwise it is discarded and `fifoWr` stays low.
- R6: A pulse on `addrW1c` clears `addrSticky`.
- R7: A pulse on `addrW1s` sets both `addrStat` and `addrSticky` to 1.
- R8: When a set of `addrSticky` (from hardware or from `addrW1s`) happens in the same cycle as `addrW1c`, the set wins.
- R9: `irq` is high exactly while `addrIntEn` and `addrSticky` are both 1.
- R10: Parity covers the data bits and the address bit. `parMode` 1 means even, 2 means odd, and 3 means the parity bit must be 1. A mismatch sets `parErr` for that frame.
- R11: `stopCfg` 0 means one stop bit. `stopCfg` 1 means one and a half stop bits, and only the first is checked. `stopCfg` 2 means two stop bits, and both are checked. A low stop sample sets `frmErr`. Both error flags are rewritten on every frame, and a frame with an error is still gated exactly as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxIn | input | 1 | Serial line, idle high |
| wordLen | input | 2 | Data bits minus 5 |
| parMode | input | 2 | 0 none, 1 even, 2 odd, 3 forced one |
| stopCfg | input | 2 | 0 one, 1 one and a half, 2 two stop bits |
| addrIntEn | input | 1 | Address interrupt enable |
| addrW1c | input | 1 | Clear strobe for the sticky address flag |
| addrW1s | input | 1 | Set strobe for the address status and sticky flags |
| fifoWr | output | 1 | One-cycle write pulse to the receive FIFO |
| fifoData | output | 8 | Received character |
| parErr | output | 1 | Parity error of the last frame |
| frmErr | output | 1 | Framing error of the last frame |
| addrStat | output | 1 | Address bit of the last frame |
| addrSticky | output | 1 | Sticky address flag |
| irq | output | 1 | Address interrupt request level |

## Verification
The assertions check on every cycle that the flag rules hold:
- a set beats a clear in the same cycle;
- a clear on its own empties the sticky flag;
- an address frame always writes and sets the sticky flag;
- no write happens without an open gate;
- at most one sampling strobe fires per cycle;
- a start glitch sends the controller back to idle.

Only the bench scenarios can show that the serial bits are assembled into the right character for each word length, that parity and stop checking match each mode, and that the gate opens and closes across a sequence of frames and software strobes.

// File: rtl/addr_uart_rx_pkg.sv
package addr_uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_ADDR, ST_PAR, ST_STOP
  } rxState_e;

  typedef struct packed {
    logic shiftData;
    logic capAddr;
    logic capPar;
    logic capStop;
    logic commit;
  } rxStrobe_t;
endpackage

// File: rtl/addr_uart_rx_ctrl.sv
module addr_uart_rx_ctrl
  import addr_uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxIn,
  input  logic [1:0] wordLen,
  input  logic [1:0] parMode,
  input  logic [1:0] stopCfg,
  output rxStrobe_t strobe
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             stopIdx;
  logic [BIT_W-1:0] lastBit;
  logic             sampleNow;
  logic             lastStop;

  assign lastBit   = BIT_W'(DATA_W - 4) + BIT_W'(wordLen);
  assign sampleNow = tick && (tickCnt == LAST_CNT);
  assign lastStop  = !stopCfg[1] || stopIdx;

  always_comb begin
    strobe = '0;
    if (sampleNow) begin
      unique case (state)
        ST_DATA: strobe.shiftData = 1'b1;
        ST_ADDR: strobe.capAddr   = 1'b1;
        ST_PAR:  strobe.capPar    = 1'b1;
        ST_STOP: begin
          strobe.capStop = 1'b1;
          strobe.commit  = lastStop;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      stopIdx <= 1'b0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          if (!rxIn) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tickCnt == MID_CNT) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= rxIn ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
        default: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            unique case (state)
              ST_DATA: begin
                if (bitCnt == lastBit) state <= ST_ADDR;
                else bitCnt <= bitCnt + BIT_W'(1);
              end
              ST_ADDR: begin
                stopIdx <= 1'b0;
                state   <= (parMode != 2'd0) ? ST_PAR : ST_STOP;
              end
              ST_PAR: begin
                stopIdx <= 1'b0;
                state   <= ST_STOP;
              end
              ST_STOP: begin
                if (lastStop) state <= ST_IDLE;
                else stopIdx <= 1'b1;
              end
              default: state <= ST_IDLE;
            endcase
          end else begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftData, strobe.capAddr, strobe.capPar, strobe.capStop}));

  // R2
  start_glitch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && tick && tickCnt == MID_CNT && rxIn) |=> (state == ST_IDLE));
endmodule

// File: rtl/addr_uart_rx_dp.sv
module addr_uart_rx_dp
  import addr_uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  rxStrobe_t         strobe,
  input  logic [1:0]        wordLen,
  input  logic [1:0]        parMode,
  input  logic              addrW1c,
  input  logic              addrW1s,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoData,
  output logic              parErr,
  output logic              frmErr,
  output logic              addrStat,
  output logic              addrSticky
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] alignedData;
  logic              addrQ;
  logic              parQ;
  logic              frmBad;
  logic              frmBadNow;
  logic              expPar;
  logic              parBad;
  logic              hwSet;

  assign alignedData = shReg >> (2'd3 - wordLen);
  assign frmBadNow   = frmBad || (strobe.capStop && !rxIn);
  assign hwSet       = strobe.commit && addrQ;

  always_comb begin
    unique case (parMode)
      2'd1:    expPar = ^alignedData ^ addrQ;
      2'd2:    expPar = ~(^alignedData ^ addrQ);
      default: expPar = 1'b1;
    endcase
  end
  assign parBad = (parMode != 2'd0) && (parQ != expPar);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg      <= '0;
      addrQ      <= 1'b0;
      parQ       <= 1'b0;
      frmBad     <= 1'b0;
      fifoWr     <= 1'b0;
      fifoData   <= '0;
      parErr     <= 1'b0;
      frmErr     <= 1'b0;
      addrStat   <= 1'b0;
      addrSticky <= 1'b0;
    end else begin
      if (strobe.shiftData) shReg <= {rxIn, shReg[DATA_W-1:1]};
      if (strobe.capAddr) begin
        addrQ  <= rxIn;
        frmBad <= 1'b0;
      end
      if (strobe.capPar) parQ <= rxIn;
      if (strobe.capStop && !rxIn) frmBad <= 1'b1;

      fifoWr <= strobe.commit && (addrQ || addrSticky);
      if (strobe.commit) begin
        fifoData <= alignedData;
        parErr   <= parBad;
        frmErr   <= frmBadNow;
      end

      if (addrW1s) addrStat <= 1'b1;
      else if (strobe.commit) addrStat <= addrQ;

      if (hwSet || addrW1s) addrSticky <= 1'b1;
      else if (addrW1c) addrSticky <= 1'b0;
    end
  end

  // R3
  stat_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !addrW1s) |=> (addrStat == $past(addrQ)));

  // R4
  addr_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && addrQ) |=> (fifoWr && addrSticky));

  // R5
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> (addrStat || $past(addrSticky)));

  // R6
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrW1c && !addrW1s && !strobe.commit) |=> !addrSticky);

  // R7
  force_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrW1s |=> (addrStat && addrSticky));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrW1c && (addrW1s || hwSet)) |=> addrSticky);
endmodule

// File: rtl/addr_uart_rx.sv
module addr_uart_rx
  import addr_uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxIn,
  input  logic [1:0]        wordLen,
  input  logic [1:0]        parMode,
  input  logic [1:0]        stopCfg,
  input  logic              addrIntEn,
  input  logic              addrW1c,
  input  logic              addrW1s,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoData,
  output logic              parErr,
  output logic              frmErr,
  output logic              addrStat,
  output logic              addrSticky,
  output logic              irq
);
  rxStrobe_t strobe;

  addr_uart_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick16),
    .rxIn    (rxIn),
    .wordLen (wordLen),
    .parMode (parMode),
    .stopCfg (stopCfg),
    .strobe  (strobe)
  );

  addr_uart_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxIn       (rxIn),
    .strobe     (strobe),
    .wordLen    (wordLen),
    .parMode    (parMode),
    .addrW1c    (addrW1c),
    .addrW1s    (addrW1s),
    .fifoWr     (fifoWr),
    .fifoData   (fifoData),
    .parErr     (parErr),
    .frmErr     (frmErr),
    .addrStat   (addrStat),
    .addrSticky (addrSticky)
  );

  assign irq = addrIntEn && addrSticky;

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!addrIntEn || !addrSticky) |-> !irq);
endmodule

// File: tb/addr_uart_rx_tb.sv
module addr_uart_rx_tb;
  localparam int BITC = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic rxIn = 1'b1;
  logic [1:0] wordLen = 2'd3, parMode = 2'd0, stopCfg = 2'd0;
  logic addrIntEn = 1'b0, addrW1c = 1'b0, addrW1s = 1'b0;
  logic fifoWr, parErr, frmErr, addrStat, addrSticky, irq;
  logic [7:0] fifoData;

  int nChk = 0, nFail = 0, wrCount = 0;
  logic [7:0] lastData = '0;
  logic expSticky = 1'b0;
  bit done = 1'b0;

  addr_uart_rx u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxIn(rxIn),
    .wordLen(wordLen), .parMode(parMode), .stopCfg(stopCfg),
    .addrIntEn(addrIntEn), .addrW1c(addrW1c), .addrW1s(addrW1s),
    .fifoWr(fifoWr), .fifoData(fifoData), .parErr(parErr), .frmErr(frmErr),
    .addrStat(addrStat), .addrSticky(addrSticky), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(negedge clk) tick16 <= rstN ? ~tick16 : 1'b0;
  always @(negedge clk) if (fifoWr) begin wrCount++; lastData = fifoData; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic holdBit(input logic b, input int n);
    rxIn = b;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] maskData(input logic [7:0] d, input logic [1:0] wl);
    return d & 8'(({1'b0, 8'hFF}) >> (3 - wl));
  endfunction

  function automatic logic parBit(input logic [7:0] d, input logic a,
                                  input logic [1:0] wl, input logic [1:0] pm);
    logic x;
    x = ^maskData(d, wl) ^ a;
    case (pm)
      2'd1: return x;
      2'd2: return ~x;
      default: return 1'b1;
    endcase
  endfunction

  task automatic pulse(input bit c, input bit s);
    addrW1c = c; addrW1s = s;
    @(negedge clk);
    addrW1c = 1'b0; addrW1s = 1'b0;
    @(negedge clk);
    if (s) expSticky = 1'b1;
    else if (c) expSticky = 1'b0;
  endtask

  // Sends one frame and checks every output against the reference model.
  task automatic frame(input logic [7:0] d, input logic a, input logic [1:0] wl,
                       input logic [1:0] pm, input logic [1:0] sc,
                       input bit badPar, input bit lowStop);
    int w0;
    bit expWr;
    w0 = wrCount;
    expWr = a || expSticky;
    wordLen = wl; parMode = pm; stopCfg = sc;
    holdBit(1'b0, BITC);
    for (int i = 0; i < int'(wl) + 5; i++) holdBit(d[i], BITC);
    holdBit(a, BITC);
    if (pm != 2'd0) holdBit(parBit(d, a, wl, pm) ^ badPar, BITC);
    holdBit(~lowStop, BITC);
    if (sc == 2'd1) holdBit(1'b1, BITC / 2);
    if (sc == 2'd2) holdBit(1'b1, BITC);
    holdBit(1'b1, 2 * BITC);
    if (a) expSticky = 1'b1;
    chk(expWr ? "R4/R5 write expected" : "R5 discard expected", wrCount - w0, {31'd0, expWr});
    if (expWr) chk("R1 character value", {24'd0, lastData}, {24'd0, maskData(d, wl)});
    chk("R3 address status", addrStat, a);
    chk("R10 parity error", parErr, badPar && pm != 2'd0);
    chk("R11 framing error", frmErr, lowStop);
    chk("R4 sticky flag", addrSticky, expSticky);
    chk("R9 irq level", irq, addrIntEn && expSticky);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 reset fifoWr", fifoWr, 1'b0);
    chk("R3 reset addrStat", addrStat, 1'b0);
    chk("R6 reset sticky", addrSticky, 1'b0);
    chk("R9 reset irq", irq, 1'b0);

    addrIntEn = 1'b1;
    frame(8'hA5, 1'b0, 2'd3, 2'd0, 2'd0, 0, 0);   // R5 gate closed
    frame(8'h53, 1'b1, 2'd3, 2'd1, 2'd0, 0, 0);   // R4 address opens gate
    frame(8'hB6, 1'b0, 2'd0, 2'd2, 2'd1, 0, 0);   // R5 data passes, 5 bits
    pulse(1, 0);
    chk("R6 clear strobe", addrSticky, 1'b0);
    chk("R9 irq after clear", irq, 1'b0);
    frame(8'h3C, 1'b0, 2'd2, 2'd0, 2'd2, 0, 0);   // R5 dropped again
    pulse(0, 1);
    chk("R7 forced status", addrStat, 1'b1);
    chk("R7 forced sticky", addrSticky, 1'b1);
    pulse(1, 1);
    chk("R8 set beats clear", addrSticky, 1'b1);
    pulse(1, 0);
    frame(8'h81, 1'b1, 2'd1, 2'd3, 2'd0, 1, 0);   // R10 bad parity, still written
    pulse(1, 0);
    frame(8'h7E, 1'b0, 2'd3, 2'd3, 2'd2, 0, 1);   // R11 low stop, dropped
    frame(8'h0F, 1'b1, 2'd2, 2'd0, 2'd0, 0, 0);
    addrIntEn = 1'b0;
    @(negedge clk);
    chk("R9 irq disabled", irq, 1'b0);

    begin : glitch_r2
      int w0;
      logic s0;
      w0 = wrCount; s0 = addrStat;
      holdBit(1'b0, 6);
      holdBit(1'b1, 3 * BITC);
      chk("R2 glitch no write", wrCount - w0, 0);
      chk("R2 glitch status kept", addrStat, s0);
    end

    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 60; n++) begin
      logic [31:0] r;
      r = $urandom();
      addrIntEn = r[20];
      if (r[19:17] < 3'd2) pulse(1, 0);
      frame(r[7:0], r[9:8] == 2'b00, r[11:10], r[13:12],
            (r[15:14] == 2'd3) ? 2'd2 : r[15:14], r[16] && r[21], r[22] && r[23] && r[24]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule